// File: doc/BRIEF.md
# ISDN Layer-1 Activation Controller

This block follows the activation state of an ISDN S/T terminal interface. It watches 4-bit command/indication codes that a line transceiver reports through a status byte and its change strobe. It also accepts activate and deactivate requests from layer 2, and a free-running timer tick. From these inputs it moves through the F-states, sends 4-bit commands back to the transceiver as a formatted byte with a write strobe, and raises one-cycle activate and deactivate indications toward layer 2.

A supervision timer (T3) bounds an activation attempt. An activate request while powered down starts the timer and asks the line to activate. If the line reaches the active state first, the timer is cancelled. Otherwise the expiry sends a deactivate command and indication. Transitions out of the active state carry a deactivate indication. The same moves between the other states are silent.

A parameter selects one of two status/command byte layouts. Another parameter sets the T3 length in ticks.

Top module: `l1_activation_ctrl`

## Requirements
- R1: After reset the state is RESET, and the command strobe and both indications are low. The state encoding on `state_o` is RESET=0, F3-powered-down=1, F3-pending-deactivation=2, F4=3, F5=4, F6=5, F7 (active)=6, F8=7.
- R2: An event is taken only in a cycle where `ci_strobe_i` is high and the change flag in the byte is set. In the basic layout the code is bits [5:2] and the flag is bit 1. In the alternative layout the code is bits [7:4] and the flag is bit 3. The code values are DR=0, RES=1, TMA=2, RSY=4, DR6=5, EI=6, PU=7, AR=8, AI8=12 and DC=15.
- R3: In any state other than F7, a RES or EI code moves to RESET and sends the DI command (15), with no indication.
- R4: In any state other than F7, an AI8 code moves to F7, sends the AR8 command (8), raises the activate indication and cancels T3.
- R5: DC moves RESET, F3-pending, F4, F5, F6 and F8 to F3-powered-down. AR moves RESET, F3-powered-down, F3-pending, F5 and F8 to F6. RSY moves F3-powered-down, F3-pending and F4 to F5, and moves F6 to F8. PU moves F3-powered-down to F4. None of these moves sends a command or raises an indication.
- R6: DR in F5 or F8, and DR6 in F6, move to F3-pending and send DI.
- R7: From F7, each of the following exits raises the deactivate indication. DR moves to F3-pending and sends DI. AR moves to F6. RSY moves to F8. RES or EI moves to RESET and sends DI.
- R8: An activate request in F3-powered-down (re)starts T3 and sends AR8. On the T3_TICKS-th tick after that start, if the state is F3-powered-down, F4, F5, F6 or F8, the block sends DI and raises the deactivate indication, and the state does not change. The timer then stops.
- R9: The command byte is {2'b00, cmd, 2'b11} in the basic layout and {cmd, 4'b1110} in the alternative layout. It is valid while `cmd_wr_o` is high.
- R10: In one cycle, an accepted code outranks a T3 expiry, and an expiry outranks a request. An outranked expiry or request is dropped, and an expired timer stops either way.
- R11: Any state/event pair not named above leaves the state unchanged and produces no outputs. This includes a deactivate request, an activate request outside F3-powered-down, and an expiry in RESET, F3-pending or F7. The state changes only after an accepted code.
- R12: All outputs are registered. They appear in the cycle after the input that caused them, and the strobe and indications last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ci_status_i | input | 8 | Command/indication status byte from the transceiver |
| ci_strobe_i | input | 1 | Status byte has been updated this cycle |
| act_req_i | input | 1 | Layer-2 activate request pulse |
| deact_req_i | input | 1 | Layer-2 deactivate request pulse |
| tick_i | input | 1 | Timer time-base tick |
| cmd_byte_o | output | 8 | Formatted command byte toward the transceiver |
| cmd_wr_o | output | 1 | Write strobe for `cmd_byte_o` |
| act_ind_o | output | 1 | Activate indication pulse to layer 2 |
| deact_ind_o | output | 1 | Deactivate indication pulse to layer 2 |
| state_o | output | 3 | Current activation state |

## Verification
The two functions that can coincide are the arrival of an accepted line code and the expiry of T3. A lower-priority activate request can also land in the same cycle as a code. The bench arms T3 in F3-powered-down and lets exactly T3_TICKS-1 ticks pass. It then applies the final tick and a PU code on the same clock. The result is judged correct only if the state moves to F4 with no DI command and no deactivate indication, and if further ticks beyond the window still produce nothing, which shows the expiry was dropped. A second case drives PU and an activate request together and checks that no AR8 is sent and that the timer never starts.

// File: rtl/l1act_pkg.sv
package l1act_pkg;

   localparam int unsigned CODE_W = 4;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_RST     = 3'd0,
      ST_F3_DOWN = 3'd1,
      ST_F3_PEND = 3'd2,
      ST_F4      = 3'd3,
      ST_F5      = 3'd4,
      ST_F6      = 3'd5,
      ST_F7      = 3'd6,
      ST_F8      = 3'd7
   } l1_state_e;

   // line indication codes
   localparam logic [CODE_W-1:0] IND_DR   = 4'd0;
   localparam logic [CODE_W-1:0] IND_RES  = 4'd1;
   localparam logic [CODE_W-1:0] IND_TMA  = 4'd2;
   localparam logic [CODE_W-1:0] IND_RSY  = 4'd4;
   localparam logic [CODE_W-1:0] IND_DR6  = 4'd5;
   localparam logic [CODE_W-1:0] IND_EI   = 4'd6;
   localparam logic [CODE_W-1:0] IND_PU   = 4'd7;
   localparam logic [CODE_W-1:0] IND_AR   = 4'd8;
   localparam logic [CODE_W-1:0] IND_AI8  = 4'd12;
   localparam logic [CODE_W-1:0] IND_DC   = 4'd15;

   // downstream command codes
   localparam logic [CODE_W-1:0] CMD_TIM  = 4'd0;
   localparam logic [CODE_W-1:0] CMD_AR8  = 4'd8;
   localparam logic [CODE_W-1:0] CMD_DI   = 4'd15;

endpackage

// File: rtl/ci_field_decode.sv
module ci_field_decode
   import l1act_pkg::*;
#(
   parameter int unsigned ALT_FMT = 0
) (
   input  logic [BYTE_W-1:0] status_i,
   input  logic              strobe_i,
   output logic [CODE_W-1:0] code_o,
   output logic              valid_o
);

   generate
      if (ALT_FMT == 0) begin : g_basic
         logic [2:0] unused_bits;
         assign unused_bits = {status_i[7:6], status_i[0]};
         assign code_o  = status_i[5:2];
         assign valid_o = strobe_i & status_i[1];
      end else begin : g_alt
         logic [2:0] unused_bits;
         assign unused_bits = status_i[2:0];
         assign code_o  = status_i[7:4];
         assign valid_o = strobe_i & status_i[3];
      end
   endgenerate

endmodule

// File: rtl/ci_cmd_encode.sv
module ci_cmd_encode
   import l1act_pkg::*;
#(
   parameter int unsigned ALT_FMT = 0
) (
   input  logic [CODE_W-1:0] cmd_i,
   output logic [BYTE_W-1:0] byte_o
);

   generate
      if (ALT_FMT == 0) begin : g_basic
         assign byte_o = {2'b00, cmd_i, 2'b11};
      end else begin : g_alt
         assign byte_o = {cmd_i, 4'b1110};
      end
   endgenerate

endmodule

// File: rtl/t3_supervisor.sv
module t3_supervisor #(
   parameter int unsigned T3_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic stop_i,
   input  logic tick_i,
   output logic expire_o
);

   localparam int unsigned CNT_W = (T3_TICKS > 2) ? $clog2(T3_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(T3_TICKS - 1);

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;

   assign expire_o = armed_q & tick_i & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (start_i) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (stop_i || expire_o) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (armed_q && tick_i) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   AST_T3_STOPS_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !start_i) |=> !armed_q); // R8
   AST_T3_COUNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (cnt_q <= LAST)); // R8

endmodule

// File: rtl/l1_transition.sv
module l1_transition
   import l1act_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_vld_i,
   input  logic [CODE_W-1:0] ev_code_i,
   input  logic              t3_exp_i,
   input  logic              act_req_i,
   input  logic              deact_req_i,
   output logic              t3_start_o,
   output logic              t3_stop_o,
   output l1_state_e         state_o,
   output logic              cmd_wr_o,
   output logic [CODE_W-1:0] cmd_o,
   output logic              act_ind_o,
   output logic              deact_ind_o
);

   l1_state_e         state_q, nxt_s;
   logic              wr_n, act_n, deact_n;
   logic [CODE_W-1:0] cmd_n;
   logic              not_f7;

   assign not_f7 = (state_q != ST_F7);

   always_comb begin
      nxt_s      = state_q;
      wr_n       = 1'b0;
      cmd_n      = CMD_TIM;
      act_n      = 1'b0;
      deact_n    = 1'b0;
      t3_start_o = 1'b0;
      t3_stop_o  = 1'b0;
      if (ev_vld_i) begin
         case (ev_code_i)
            IND_RES, IND_EI: begin
               nxt_s   = ST_RST;
               wr_n    = 1'b1;
               cmd_n   = CMD_DI;
               deact_n = !not_f7;
            end
            IND_AI8: if (not_f7) begin
               nxt_s     = ST_F7;
               wr_n      = 1'b1;
               cmd_n     = CMD_AR8;
               act_n     = 1'b1;
               t3_stop_o = 1'b1;
            end
            IND_DC: if (state_q inside {ST_RST, ST_F3_PEND, ST_F4, ST_F5, ST_F6, ST_F8})
               nxt_s = ST_F3_DOWN;
            IND_AR: begin
               if (state_q inside {ST_RST, ST_F3_DOWN, ST_F3_PEND, ST_F5, ST_F8})
                  nxt_s = ST_F6;
               else if (!not_f7) begin
                  nxt_s   = ST_F6;
                  deact_n = 1'b1;
               end
            end
            IND_RSY: begin
               if (state_q inside {ST_F3_DOWN, ST_F3_PEND, ST_F4})
                  nxt_s = ST_F5;
               else if (state_q == ST_F6)
                  nxt_s = ST_F8;
               else if (!not_f7) begin
                  nxt_s   = ST_F8;
                  deact_n = 1'b1;
               end
            end
            IND_PU: if (state_q == ST_F3_DOWN)
               nxt_s = ST_F4;
            IND_DR: if (state_q inside {ST_F5, ST_F8, ST_F7}) begin
               nxt_s   = ST_F3_PEND;
               wr_n    = 1'b1;
               cmd_n   = CMD_DI;
               deact_n = !not_f7;
            end
            IND_DR6: if (state_q == ST_F6) begin
               nxt_s = ST_F3_PEND;
               wr_n  = 1'b1;
               cmd_n = CMD_DI;
            end
            default: ;
         endcase
      end else if (t3_exp_i) begin
         if (state_q inside {ST_F3_DOWN, ST_F4, ST_F5, ST_F6, ST_F8}) begin
            wr_n    = 1'b1;
            cmd_n   = CMD_DI;
            deact_n = 1'b1;
         end
      end else if (act_req_i) begin
         if (state_q == ST_F3_DOWN) begin
            wr_n       = 1'b1;
            cmd_n      = CMD_AR8;
            t3_start_o = 1'b1;
         end
      end else if (deact_req_i) begin
         nxt_s = state_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_RST;
         cmd_wr_o    <= 1'b0;
         cmd_o       <= CMD_TIM;
         act_ind_o   <= 1'b0;
         deact_ind_o <= 1'b0;
      end else begin
         state_q     <= nxt_s;
         cmd_wr_o    <= wr_n;
         cmd_o       <= cmd_n;
         act_ind_o   <= act_n;
         deact_ind_o <= deact_n;
      end
   end

   assign state_o = state_q;

   AST_ACT_ENTERS_F7: assert property (@(posedge clk) disable iff (!rst_n)
      act_ind_o |-> (state_q == ST_F7 && $past(state_q) != ST_F7)); // R4
   AST_F7_EXIT_DEACT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_F7 && state_q != ST_F7) |-> deact_ind_o); // R7
   AST_IND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_ind_o && deact_ind_o)); // R4
   AST_ACT_WITH_AR8: assert property (@(posedge clk) disable iff (!rst_n)
      act_ind_o |-> (cmd_wr_o && cmd_o == CMD_AR8)); // R4

endmodule

// File: rtl/l1_activation_ctrl.sv
module l1_activation_ctrl
   import l1act_pkg::*;
#(
   parameter int unsigned ALT_FMT  = 0,
   parameter int unsigned T3_TICKS = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  ci_status_i,
   input  logic        ci_strobe_i,
   input  logic        act_req_i,
   input  logic        deact_req_i,
   input  logic        tick_i,
   output logic [7:0]  cmd_byte_o,
   output logic        cmd_wr_o,
   output logic        act_ind_o,
   output logic        deact_ind_o,
   output logic [2:0]  state_o
);

   generate
      if (T3_TICKS < 2) begin : g_bad_t3
         $error("T3_TICKS must be at least 2");
      end
      if (ALT_FMT > 1) begin : g_bad_fmt
         $error("ALT_FMT must be 0 or 1");
      end
   endgenerate

   logic [CODE_W-1:0] ev_code, cmd_code;
   logic              ev_vld, t3_exp, t3_start, t3_stop;
   l1_state_e         st;

   ci_field_decode #(.ALT_FMT(ALT_FMT)) u_dec (
      .status_i (ci_status_i),
      .strobe_i (ci_strobe_i),
      .code_o   (ev_code),
      .valid_o  (ev_vld)
   );

   t3_supervisor #(.T3_TICKS(T3_TICKS)) u_t3 (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (t3_start),
      .stop_i   (t3_stop),
      .tick_i   (tick_i),
      .expire_o (t3_exp)
   );

   l1_transition u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_vld_i    (ev_vld),
      .ev_code_i   (ev_code),
      .t3_exp_i    (t3_exp),
      .act_req_i   (act_req_i),
      .deact_req_i (deact_req_i),
      .t3_start_o  (t3_start),
      .t3_stop_o   (t3_stop),
      .state_o     (st),
      .cmd_wr_o    (cmd_wr_o),
      .cmd_o       (cmd_code),
      .act_ind_o   (act_ind_o),
      .deact_ind_o (deact_ind_o)
   );

   ci_cmd_encode #(.ALT_FMT(ALT_FMT)) u_enc (
      .cmd_i  (cmd_code),
      .byte_o (cmd_byte_o)
   );

   assign state_o = st;

   AST_STATE_MOVES_ON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != $past(state_o)) |-> $past(ci_strobe_i)); // R11
   AST_ACT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      act_ind_o |=> !act_ind_o); // R12

endmodule

// File: tb/tb_l1_activation_ctrl.sv
`timescale 1ns/1ps
module tb_l1_activation_ctrl;

   localparam int T3 = 12;

   localparam int S_RST = 0, S_F3D = 1, S_F3P = 2, S_F4 = 3,
                  S_F5 = 4, S_F6 = 5, S_F7 = 6, S_F8 = 7;
   localparam logic [3:0] C_DR = 0, C_RES = 1, C_TMA = 2, C_RSY = 4, C_DR6 = 5,
                          C_EI = 6, C_PU = 7, C_AR = 8, C_AI8 = 12, C_DC = 15;
   localparam logic [3:0] K_AR8 = 8, K_DI = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] st_b = '0, st_a = '0;
   logic strobe = 1'b0, act_req = 1'b0, deact_req = 1'b0, tick = 1'b0;

   logic [7:0] cmd_b, cmd_a;
   logic wr_b, wr_a, act_b, act_a, deact_b, deact_a;
   logic [2:0] state_b, state_a;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   l1_activation_ctrl #(.ALT_FMT(0), .T3_TICKS(T3)) dut (
      .clk(clk), .rst_n(rst_n), .ci_status_i(st_b), .ci_strobe_i(strobe),
      .act_req_i(act_req), .deact_req_i(deact_req), .tick_i(tick),
      .cmd_byte_o(cmd_b), .cmd_wr_o(wr_b), .act_ind_o(act_b),
      .deact_ind_o(deact_b), .state_o(state_b));

   l1_activation_ctrl #(.ALT_FMT(1), .T3_TICKS(T3)) dut_alt (
      .clk(clk), .rst_n(rst_n), .ci_status_i(st_a), .ci_strobe_i(strobe),
      .act_req_i(act_req), .deact_req_i(deact_req), .tick_i(tick),
      .cmd_byte_o(cmd_a), .cmd_wr_o(wr_a), .act_ind_o(act_a),
      .deact_ind_o(deact_a), .state_o(state_a));

   task automatic chk(input bit ok, input string tag, input string what,
                      input int actual, input int expected);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, actual, expected);
      end
   endtask

   // sampled at a negedge, one edge after the stimulus
   task automatic expect_out(input string tag, input int st, input bit wr,
                             input logic [3:0] cmd, input bit a, input bit d);
      chk(state_b == st, tag, "state basic", state_b, st);
      chk(state_a == st, tag, "state alt", state_a, st);
      chk(wr_b == wr && wr_a == wr, tag, "cmd strobe", {wr_b, wr_a}, {wr, wr});
      if (wr) begin
         chk(cmd_b == {2'b00, cmd, 2'b11}, tag, "cmd byte basic (R9)", cmd_b, {2'b00, cmd, 2'b11});
         chk(cmd_a == {cmd, 4'b1110}, tag, "cmd byte alt (R9)", cmd_a, {cmd, 4'b1110});
      end
      chk(act_b == a && act_a == a, tag, "act ind", {act_b, act_a}, {a, a});
      chk(deact_b == d && deact_a == d, tag, "deact ind", {deact_b, deact_a}, {d, d});
   endtask

   task automatic send_ci(input logic [3:0] code, input bit flag, input bit with_tick,
                          input bit with_act);
      @(negedge clk);
      st_b = {2'b00, code, flag, 1'b0};
      st_a = {code, flag, 3'b000};
      strobe = 1'b1;
      tick = with_tick;
      act_req = with_act;
      @(negedge clk);
      strobe = 1'b0;
      tick = 1'b0;
      act_req = 1'b0;
   endtask

   task automatic ci(input logic [3:0] code);
      send_ci(code, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic pulse_act();
      @(negedge clk); act_req = 1'b1;
      @(negedge clk); act_req = 1'b0;
   endtask

   task automatic one_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic quiet_ticks(input int n, input int st, input string tag);
      for (int i = 0; i < n; i++) begin
         one_tick();
         expect_out(tag, st, 0, 0, 0, 0);
      end
   endtask

   task automatic t_reset();
      expect_out("R1", S_RST, 0, 0, 0, 0);
   endtask

   task automatic t_walk();
      ci(C_DC);  expect_out("R5", S_F3D, 0, 0, 0, 0);
      ci(C_PU);  expect_out("R5", S_F4, 0, 0, 0, 0);
      ci(C_RSY); expect_out("R5", S_F5, 0, 0, 0, 0);
      ci(C_AR);  expect_out("R5", S_F6, 0, 0, 0, 0);
      ci(C_RSY); expect_out("R5", S_F8, 0, 0, 0, 0);
      ci(C_AI8); expect_out("R4", S_F7, 1, K_AR8, 1, 0);
      @(negedge clk);
      expect_out("R12", S_F7, 0, 0, 0, 0);
   endtask

   task automatic t_f7_exits();
      ci(C_RSY); expect_out("R7", S_F8, 0, 0, 0, 1);
      ci(C_AI8); expect_out("R4", S_F7, 1, K_AR8, 1, 0);
      ci(C_AR);  expect_out("R7", S_F6, 0, 0, 0, 1);
      ci(C_AI8); expect_out("R4", S_F7, 1, K_AR8, 1, 0);
      ci(C_DR);  expect_out("R7", S_F3P, 1, K_DI, 0, 1);
      ci(C_AI8); expect_out("R4", S_F7, 1, K_AR8, 1, 0);
      ci(C_RES); expect_out("R7", S_RST, 1, K_DI, 0, 1);
      ci(C_AI8); expect_out("R4", S_F7, 1, K_AR8, 1, 0);
      ci(C_AI8); expect_out("R11", S_F7, 0, 0, 0, 0);
      ci(C_EI);  expect_out("R7", S_RST, 1, K_DI, 0, 1);
   endtask

   task automatic t_reset_codes();
      ci(C_AR);  expect_out("R5", S_F6, 0, 0, 0, 0);
      ci(C_EI);  expect_out("R3", S_RST, 1, K_DI, 0, 0);
      ci(C_DC);  expect_out("R5", S_F3D, 0, 0, 0, 0);
      ci(C_RES); expect_out("R3", S_RST, 1, K_DI, 0, 0);
   endtask

   task automatic t_drop_codes();
      ci(C_AR);  expect_out("R5", S_F6, 0, 0, 0, 0);
      ci(C_DR6); expect_out("R6", S_F3P, 1, K_DI, 0, 0);
      ci(C_RSY); expect_out("R5", S_F5, 0, 0, 0, 0);
      ci(C_DR);  expect_out("R6", S_F3P, 1, K_DI, 0, 0);
      ci(C_AR);  expect_out("R5", S_F6, 0, 0, 0, 0);
      ci(C_RSY); expect_out("R5", S_F8, 0, 0, 0, 0);
      ci(C_DR);  expect_out("R6", S_F3P, 1, K_DI, 0, 0);
   endtask

   task automatic t_ignored();
      ci(C_PU);  expect_out("R11", S_F3P, 0, 0, 0, 0);
      ci(C_TMA); expect_out("R11", S_F3P, 0, 0, 0, 0);
      send_ci(C_AI8, 1'b0, 1'b0, 1'b0);
      expect_out("R2", S_F3P, 0, 0, 0, 0);
      @(negedge clk); deact_req = 1'b1;
      @(negedge clk); deact_req = 1'b0;
      expect_out("R11", S_F3P, 0, 0, 0, 0);
      pulse_act();
      expect_out("R11", S_F3P, 0, 0, 0, 0);
   endtask

   task automatic t_t3_expiry();
      ci(C_DC); expect_out("R5", S_F3D, 0, 0, 0, 0);
      pulse_act();
      expect_out("R8", S_F3D, 1, K_AR8, 0, 0);
      quiet_ticks(T3 - 1, S_F3D, "R8");
      one_tick();
      expect_out("R8", S_F3D, 1, K_DI, 0, 1);
      quiet_ticks(T3 + 1, S_F3D, "R8");
      pulse_act();
      expect_out("R8", S_F3D, 1, K_AR8, 0, 0);
      quiet_ticks(3, S_F3D, "R8");
      ci(C_PU); expect_out("R5", S_F4, 0, 0, 0, 0);
      quiet_ticks(T3 - 4, S_F4, "R8");
      one_tick();
      expect_out("R8", S_F4, 1, K_DI, 0, 1);
   endtask

   task automatic t_t3_cancel();
      ci(C_DC); expect_out("R5", S_F3D, 0, 0, 0, 0);
      pulse_act();
      expect_out("R8", S_F3D, 1, K_AR8, 0, 0);
      quiet_ticks(2, S_F3D, "R8");
      ci(C_AI8); expect_out("R4", S_F7, 1, K_AR8, 1, 0);
      ci(C_RSY); expect_out("R7", S_F8, 0, 0, 0, 1);
      quiet_ticks(T3 + 2, S_F8, "R4");
   endtask

   task automatic t_collide();
      ci(C_DC); expect_out("R5", S_F3D, 0, 0, 0, 0);
      pulse_act();
      expect_out("R8", S_F3D, 1, K_AR8, 0, 0);
      quiet_ticks(T3 - 1, S_F3D, "R8");
      send_ci(C_PU, 1'b1, 1'b1, 1'b0);
      expect_out("R10", S_F4, 0, 0, 0, 0);
      quiet_ticks(T3 + 1, S_F4, "R10");
      ci(C_DC); expect_out("R5", S_F3D, 0, 0, 0, 0);
      send_ci(C_PU, 1'b1, 1'b0, 1'b1);
      expect_out("R10", S_F4, 0, 0, 0, 0);
      quiet_ticks(T3 + 1, S_F4, "R10");
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_walk();
      t_f7_exits();
      t_reset_codes();
      t_drop_codes();
      t_ignored();
      t_t3_expiry();
      t_t3_cancel();
      t_collide();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule